// File: doc/BRIEF.md
# LCD Dot-Clock Timing Generator

This block generates the raster timing for a parallel RGB display panel, advancing one position per dot clock. A horizontal counter walks through each line and a vertical counter walks through the lines of a frame. From these two counts the block derives the horizontal sync, vertical sync and data-enable strobes, a raw pixel request for the fetch logic, and two markers: one at the start of each frame and one at the first active pixel of each active line. Each timing quantity is programmed as its own input. The wait counts already include the sync width, so each one is "sync plus back porch". Each of the three panel strobes has its own polarity select.

A control machine starts the raster only when the sync outputs were enabled beforehand. On a stop request it keeps scanning until the downstream pixel FIFO reports empty, and only then drops its run status. A next-buffer base address can be written at any time. It is copied into the current-buffer address only at a frame boundary, so the address being scanned never changes in the middle of a frame.

Top module: `lcd_dotclk_timing`

## Requirements
- R1: While running, the horizontal count steps 0..cfgHTotal-1 and then wraps, and the vertical count advances once per wrap through 0..cfgVTotal-1. A frame therefore lasts cfgHTotal*cfgVTotal clocks.
- R2: The internal hsync is active while the horizontal count is below cfgHSyncWidth. The internal vsync is active on every clock of lines whose vertical count is below cfgVSyncWidth.
- R3: pixReqO (always active high) is 1 when the horizontal count lies in [cfgHWait, cfgHWait+cfgHActive) and the vertical count lies in [cfgVWait, cfgVWait+cfgVActive). This gives cfgHActive requests per active line and cfgHActive*cfgVActive per frame.
- R4: hsyncO, vsyncO and deO each equal their select bit (cfgHsyncHigh, cfgVsyncHigh, cfgDeHigh) when active, and the inverse of that bit when inactive. A select bit of 0 gives an active-low output.
- R5: frameStartO pulses for one clock when both counts are 0. lineStartO pulses on the first pixel request of each active line, so cfgVActive times per frame.
- R6: A start happens at a clock edge where runReq is 1 and syncEn was already 1 at the previous edge. runReq has no effect while syncEn is low. runStatus rises after the start edge, and the first running cycle has both counts at 0.
- R7: After runReq falls, runStatus stays 1 and the timing keeps running until an edge that samples fifoEmpty high. runStatus falls after that edge.
- R8: From the cycle after an edge that samples syncEn low, every timing output sits at its inactive level while the counts keep advancing.
- R9: While not running, the counts are held at 0 and every timing output sits at its inactive level.
- R10: curBufAddr loads the next-buffer register value at the start edge and at the edge that wraps the last clock of a frame. At all other edges it holds. A nextBufWe write updates only the next-buffer register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgHTotal | input | CNT_W | Dot clocks per line |
| cfgHSyncWidth | input | CNT_W | Hsync width in dot clocks |
| cfgHWait | input | CNT_W | Hsync width plus back porch |
| cfgHActive | input | CNT_W | Active pixels per line |
| cfgVTotal | input | CNT_W | Lines per frame |
| cfgVSyncWidth | input | CNT_W | Vsync width in lines |
| cfgVWait | input | CNT_W | Vsync width plus back porch, in lines |
| cfgVActive | input | CNT_W | Active lines per frame |
| cfgHsyncHigh | input | 1 | Hsync active-high select |
| cfgVsyncHigh | input | 1 | Vsync active-high select |
| cfgDeHigh | input | 1 | Data-enable active-high select |
| syncEn | input | 1 | Sync output enable |
| runReq | input | 1 | Run request |
| fifoEmpty | input | 1 | Downstream pixel FIFO is empty |
| nextBufWe | input | 1 | Write strobe for the next-buffer address |
| nextBufAddr | input | ADDR_W | Next-buffer base address |
| hsyncO | output | 1 | Horizontal sync, polarity applied |
| vsyncO | output | 1 | Vertical sync, polarity applied |
| deO | output | 1 | Data enable, polarity applied |
| pixReqO | output | 1 | Active-high pixel request |
| frameStartO | output | 1 | Frame start pulse |
| lineStartO | output | 1 | Active-line start pulse |
| runStatus | output | 1 | Raster running, including the drain phase |
| curBufAddr | output | ADDR_W | Buffer address being scanned |

## Verification
The bench targets the edges of the active window: zero front and back porches, a single-pixel active width, and active regions that end on the last clock of a line. An off-by-one comparison here would show up as one missing or one extra pixel request per line, or as a lineStartO that lands one clock early. It also issues a run request while sync is disabled, which a wrong design would accept. It holds fifoEmpty low for several cycles during a stop; a design that ignores the drain would drop runStatus early. Buffer writes are scattered through the frame. Any swap that is not aligned to the frame boundary would show up as curBufAddr changing mid-frame.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } lcdt_state_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic start;    // idle -> run transition at this edge
    logic advance;  // raster counters step this cycle
    logic syncOn;   // registered sync enable
  } lcdt_strobe_t;

endpackage

// File: rtl/lcdt_ctrl.sv
module lcdt_ctrl
  import lcdt_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         syncEn,
  input  logic         runReq,
  input  logic         fifoEmpty,
  output lcdt_strobe_t strb,
  output logic         runStatus
);

  lcdt_state_e stateQ, stateD;
  logic        syncOnQ;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:  if (runReq && syncOnQ) stateD = ST_RUN;
      ST_RUN:   if (!runReq)           stateD = ST_DRAIN;
      ST_DRAIN: if (fifoEmpty)         stateD = ST_IDLE;
      default:                         stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      syncOnQ <= 1'b0;
    end else begin
      stateQ  <= stateD;
      syncOnQ <= syncEn;
    end
  end

  assign strb.start   = (stateQ == ST_IDLE) && runReq && syncOnQ;
  assign strb.advance = (stateQ != ST_IDLE);
  assign strb.syncOn  = syncOnQ;
  assign runStatus    = (stateQ != ST_IDLE);

  AST_NO_START_WITHOUT_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && !syncOnQ) |=> (stateQ == ST_IDLE)); // R6

  AST_DRAIN_WAITS_FIFO: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_DRAIN && !fifoEmpty) |=> (stateQ != ST_IDLE)); // R7

endmodule

// File: rtl/lcdt_datapath.sv
module lcdt_datapath
  import lcdt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  lcdt_strobe_t      strb,
  input  logic [CNT_W-1:0]  cfgHTotal,
  input  logic [CNT_W-1:0]  cfgHSyncWidth,
  input  logic [CNT_W-1:0]  cfgHWait,
  input  logic [CNT_W-1:0]  cfgHActive,
  input  logic [CNT_W-1:0]  cfgVTotal,
  input  logic [CNT_W-1:0]  cfgVSyncWidth,
  input  logic [CNT_W-1:0]  cfgVWait,
  input  logic [CNT_W-1:0]  cfgVActive,
  input  logic              cfgHsyncHigh,
  input  logic              cfgVsyncHigh,
  input  logic              cfgDeHigh,
  input  logic              nextBufWe,
  input  logic [ADDR_W-1:0] nextBufAddr,
  output logic              hsyncO,
  output logic              vsyncO,
  output logic              deO,
  output logic              pixReqO,
  output logic              frameStartO,
  output logic              lineStartO,
  output logic [ADDR_W-1:0] curBufAddr
);

  localparam int EW    = CNT_W + 1;
  localparam int N_POL = 3;

  logic [CNT_W-1:0]  hCntQ, vCntQ;
  logic [EW-1:0]     hNext, vNext;
  logic              hEnd, vEnd, hInWin, vInWin, running, swap;
  logic [N_POL-1:0]  rawAct, polSel, polOut;
  logic [ADDR_W-1:0] nextBufQ, curBufQ;

  assign hNext  = {1'b0, hCntQ} + EW'(1);
  assign vNext  = {1'b0, vCntQ} + EW'(1);
  assign hEnd   = hNext >= {1'b0, cfgHTotal};
  assign vEnd   = vNext >= {1'b0, cfgVTotal};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCntQ <= '0;
      vCntQ <= '0;
    end else if (!strb.advance) begin
      hCntQ <= '0;
      vCntQ <= '0;
    end else if (hEnd) begin
      hCntQ <= '0;
      vCntQ <= vEnd ? '0 : vNext[CNT_W-1:0];
    end else begin
      hCntQ <= hNext[CNT_W-1:0];
    end
  end

  assign hInWin = ({1'b0, hCntQ} >= {1'b0, cfgHWait}) &&
                  ({1'b0, hCntQ} <  ({1'b0, cfgHWait} + {1'b0, cfgHActive}));
  assign vInWin = ({1'b0, vCntQ} >= {1'b0, cfgVWait}) &&
                  ({1'b0, vCntQ} <  ({1'b0, cfgVWait} + {1'b0, cfgVActive}));

  assign running   = strb.advance & strb.syncOn;
  assign rawAct[0] = running & (hCntQ < cfgHSyncWidth);
  assign rawAct[1] = running & (vCntQ < cfgVSyncWidth);
  assign rawAct[2] = running & hInWin & vInWin;
  assign polSel    = {cfgDeHigh, cfgVsyncHigh, cfgHsyncHigh};

  for (genvar gi = 0; gi < N_POL; gi++) begin : g_pol
    assign polOut[gi] = rawAct[gi] ? polSel[gi] : ~polSel[gi];
  end

  assign hsyncO      = polOut[0];
  assign vsyncO      = polOut[1];
  assign deO         = polOut[2];
  assign pixReqO     = rawAct[2];
  assign frameStartO = running & (hCntQ == '0) & (vCntQ == '0);
  assign lineStartO  = running & vInWin & (hCntQ == cfgHWait) & (cfgHActive != '0);

  // buffer base: next register, swapped into current at frame boundary
  assign swap = strb.start | (strb.advance & hEnd & vEnd);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nextBufQ <= '0;
      curBufQ  <= '0;
    end else begin
      if (nextBufWe) nextBufQ <= nextBufAddr;
      if (swap)      curBufQ  <= nextBufQ;
    end
  end

  assign curBufAddr = curBufQ;

  AST_H_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && hEnd) |=> (hCntQ == '0)); // R1

  AST_START_AT_ORIGIN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.advance) |-> (hCntQ == '0 && vCntQ == '0)); // R6

  AST_BUF_MIDFRAME_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !(hEnd && vEnd)) |=> $stable(curBufQ)); // R10

endmodule

// File: rtl/lcd_dotclk_timing.sv
module lcd_dotclk_timing
  import lcdt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  cfgHTotal,
  input  logic [CNT_W-1:0]  cfgHSyncWidth,
  input  logic [CNT_W-1:0]  cfgHWait,
  input  logic [CNT_W-1:0]  cfgHActive,
  input  logic [CNT_W-1:0]  cfgVTotal,
  input  logic [CNT_W-1:0]  cfgVSyncWidth,
  input  logic [CNT_W-1:0]  cfgVWait,
  input  logic [CNT_W-1:0]  cfgVActive,
  input  logic              cfgHsyncHigh,
  input  logic              cfgVsyncHigh,
  input  logic              cfgDeHigh,
  input  logic              syncEn,
  input  logic              runReq,
  input  logic              fifoEmpty,
  input  logic              nextBufWe,
  input  logic [ADDR_W-1:0] nextBufAddr,
  output logic              hsyncO,
  output logic              vsyncO,
  output logic              deO,
  output logic              pixReqO,
  output logic              frameStartO,
  output logic              lineStartO,
  output logic              runStatus,
  output logic [ADDR_W-1:0] curBufAddr
);

  lcdt_strobe_t strb;

  lcdt_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .syncEn    (syncEn),
    .runReq    (runReq),
    .fifoEmpty (fifoEmpty),
    .strb      (strb),
    .runStatus (runStatus)
  );

  lcdt_datapath #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .cfgHTotal     (cfgHTotal),
    .cfgHSyncWidth (cfgHSyncWidth),
    .cfgHWait      (cfgHWait),
    .cfgHActive    (cfgHActive),
    .cfgVTotal     (cfgVTotal),
    .cfgVSyncWidth (cfgVSyncWidth),
    .cfgVWait      (cfgVWait),
    .cfgVActive    (cfgVActive),
    .cfgHsyncHigh  (cfgHsyncHigh),
    .cfgVsyncHigh  (cfgVsyncHigh),
    .cfgDeHigh     (cfgDeHigh),
    .nextBufWe     (nextBufWe),
    .nextBufAddr   (nextBufAddr),
    .hsyncO        (hsyncO),
    .vsyncO        (vsyncO),
    .deO           (deO),
    .pixReqO       (pixReqO),
    .frameStartO   (frameStartO),
    .lineStartO    (lineStartO),
    .curBufAddr    (curBufAddr)
  );

  AST_IDLE_INACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    !runStatus |-> (hsyncO == !cfgHsyncHigh && vsyncO == !cfgVsyncHigh &&
                    deO == !cfgDeHigh && !pixReqO && !frameStartO && !lineStartO)); // R9

endmodule

// File: tb/lcd_dotclk_timing_tb.sv
module lcd_dotclk_timing_tb;

  localparam int CW = 16;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CW-1:0] cHT, cHS, cHW, cHA, cVT, cVS, cVW, cVA;
  logic cHsHi, cVsHi, cDeHi;
  logic syncEn, runReq, fifoEmpty, nextBufWe;
  logic [AW-1:0] nextBufAddr;
  logic hsyncO, vsyncO, deO, pixReqO, frameStartO, lineStartO, runStatus;
  logic [AW-1:0] curBufAddr;

  int nChecks = 0;
  int nFail = 0;
  bit chkEn = 1'b0;
  bit done = 1'b0;

  // requirement-level model state
  int mState;  // 0 idle, 1 run, 2 drain
  int mH, mV;
  bit mSyncOn;
  logic [AW-1:0] mNext, mCur;

  always #2 clk = ~clk;

  lcd_dotclk_timing #(.CNT_W(CW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN),
    .cfgHTotal(cHT), .cfgHSyncWidth(cHS), .cfgHWait(cHW), .cfgHActive(cHA),
    .cfgVTotal(cVT), .cfgVSyncWidth(cVS), .cfgVWait(cVW), .cfgVActive(cVA),
    .cfgHsyncHigh(cHsHi), .cfgVsyncHigh(cVsHi), .cfgDeHigh(cDeHi),
    .syncEn(syncEn), .runReq(runReq), .fifoEmpty(fifoEmpty),
    .nextBufWe(nextBufWe), .nextBufAddr(nextBufAddr),
    .hsyncO(hsyncO), .vsyncO(vsyncO), .deO(deO), .pixReqO(pixReqO),
    .frameStartO(frameStartO), .lineStartO(lineStartO),
    .runStatus(runStatus), .curBufAddr(curBufAddr)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic lvl(input bit act, input logic hi);
    return act ? hi : !hi;
  endfunction

  function automatic bit inWin(input int c, input int w, input int a);
    return (c >= w) && (c < w + a);
  endfunction

  function automatic bit onNow();
    return (mState != 0) && mSyncOn;
  endfunction

  // model advance at the active edge
  always @(posedge clk) begin
    if (!rstN) begin
      mState <= 0; mH <= 0; mV <= 0; mSyncOn <= 1'b0; mNext <= '0; mCur <= '0;
    end else begin
      mSyncOn <= syncEn;
      if (nextBufWe) mNext <= nextBufAddr;
      case (mState)
        0: if (runReq && mSyncOn) begin mState <= 1; mCur <= mNext; end
        1: if (!runReq) mState <= 2;
        default: if (fifoEmpty) mState <= 0;
      endcase
      if (mState == 0) begin
        mH <= 0; mV <= 0;
      end else if (mH + 1 >= int'(cHT)) begin
        mH <= 0;
        if (mV + 1 >= int'(cVT)) begin mV <= 0; mCur <= mNext; end
        else mV <= mV + 1;
      end else begin
        mH <= mH + 1;
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (chkEn) begin
      bit on;
      bit de;
      on = onNow();
      de = on && inWin(mH, int'(cHW), int'(cHA)) && inWin(mV, int'(cVW), int'(cVA));
      chk("R2 R4 R8 hsync", 64'(hsyncO), 64'(lvl(on && mH < int'(cHS), cHsHi)));
      chk("R2 R4 R8 vsync", 64'(vsyncO), 64'(lvl(on && mV < int'(cVS), cVsHi)));
      chk("R3 R4 de", 64'(deO), 64'(lvl(de, cDeHi)));
      chk("R3 R9 pixReq", 64'(pixReqO), 64'(de));
      chk("R5 frameStart", 64'(frameStartO), 64'(on && mH == 0 && mV == 0));
      chk("R5 lineStart", 64'(lineStartO),
          64'(on && mH == int'(cHW) && inWin(mV, int'(cVW), int'(cVA))));
      chk("R6 R7 runStatus", 64'(runStatus), 64'(mState != 0));
      chk("R10 curBuf", 64'(curBufAddr), 64'(mCur));
    end
  end

  task automatic setCfg(input int hs, input int hbp, input int ha, input int hfp,
                        input int vs, input int vbp, input int va, input int vfp);
    cHS = CW'(hs); cHW = CW'(hs + hbp); cHA = CW'(ha); cHT = CW'(hs + hbp + ha + hfp);
    cVS = CW'(vs); cVW = CW'(vs + vbp); cVA = CW'(va); cVT = CW'(vs + vbp + va + vfp);
    cHsHi = 1'($urandom % 2); cVsHi = 1'($urandom % 2); cDeHi = 1'($urandom % 2);
  endtask

  task automatic scenario(input bit toggleSync);
    int period, pix, lines, drainWait;
    syncEn = 1'b1;
    repeat (2) @(negedge clk);
    runReq = 1'b1;
    @(negedge clk);
    chk("R6 started", 64'(runStatus), 64'd1);
    chk("R6 origin frameStart", 64'(frameStartO), 64'd1);
    // measure one frame from the next frame start
    do begin
      @(negedge clk);
      nextBufWe = 1'($urandom % 4 == 0); nextBufAddr = $urandom;
    end while (!frameStartO);
    period = 0; pix = 0; lines = 0;
    do begin
      @(negedge clk);
      nextBufWe = 1'($urandom % 4 == 0); nextBufAddr = $urandom;
      period++;
      if (!frameStartO) begin
        if (pixReqO) pix++;
        if (lineStartO) lines++;
      end
    end while (!frameStartO);
    nextBufWe = 1'b0;
    chk("R1 frame period", 64'(period), 64'(int'(cHT) * int'(cVT)));
    chk("R3 pixels per frame", 64'(pix), 64'(int'(cHA) * int'(cVA)));
    chk("R5 lines per frame", 64'(lines), 64'(cVA));
    if (toggleSync) begin
      syncEn = 1'b0;
      repeat (2 * int'(cHT)) @(negedge clk);
      chk("R8 hsync parked", 64'(hsyncO), 64'(!cHsHi));
      chk("R8 still running", 64'(runStatus), 64'd1);
      syncEn = 1'b1;
      repeat (int'(cHT) * int'(cVT)) @(negedge clk);
    end
    // stop with a drain
    fifoEmpty = 1'b0;
    runReq = 1'b0;
    drainWait = 3 + int'($urandom % 6);
    repeat (drainWait) @(negedge clk);
    chk("R7 held during drain", 64'(runStatus), 64'd1);
    fifoEmpty = 1'b1;
    for (int k = 0; k < 4 && runStatus; k++) @(negedge clk);
    chk("R7 stopped after drain", 64'(runStatus), 64'd0);
    @(negedge clk);
    chk("R9 idle de parked", 64'(deO), 64'(!cDeHi));
    fifoEmpty = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    syncEn = 1'b0; runReq = 1'b0; fifoEmpty = 1'b0; nextBufWe = 1'b0; nextBufAddr = '0;
    setCfg(2, 1, 4, 2, 1, 1, 2, 1);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R9 reset runStatus", 64'(runStatus), 64'd0);
    chk("R9 reset curBuf", 64'(curBufAddr), 64'd0);
    chk("R9 reset hsync", 64'(hsyncO), 64'(!cHsHi));
    chkEn = 1'b1;
    // run request without sync enable is ignored
    runReq = 1'b1;
    repeat (6) @(negedge clk);
    chk("R6 no start without sync", 64'(runStatus), 64'd0);
    runReq = 1'b0;
    // buffer written while idle is not visible until a start
    nextBufWe = 1'b1; nextBufAddr = 32'hA5A5_0000;
    @(negedge clk);
    nextBufWe = 1'b0;
    chk("R10 idle write not visible", 64'(curBufAddr), 64'd0);
    // directed corners: zero porches, single-pixel line, active to line end
    setCfg(1, 0, 1, 0, 1, 0, 1, 0);
    scenario(1'b0);
    setCfg(3, 0, 5, 0, 2, 0, 3, 0);
    scenario(1'b1);
    setCfg(1, 2, 1, 3, 1, 1, 1, 2);
    scenario(1'b0);
    for (int s = 0; s < 8; s++) begin
      setCfg(1 + int'($urandom % 3), int'($urandom % 3), 1 + int'($urandom % 6),
             int'($urandom % 3), 1 + int'($urandom % 2), int'($urandom % 2),
             1 + int'($urandom % 4), int'($urandom % 2));
      scenario(1'($urandom % 2));
    end
    chkEn = 1'b0;
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule